// File: doc/BRIEF.md
# I2C Write Sequence Player

This block replays a stored list of I2C write transactions when the system changes power state. Two sequences are kept in a byte store: one for entering sleep and one for waking up. Each is described by a base offset and a total byte count. A pulse on `sleep_req` or `wake_req` starts playback of the matching sequence. The block reads the store one byte at a time through a synchronous read port. Each message in the store is a length byte, a 7-bit target address byte, and then that many payload bytes.

Every message becomes one write transaction on a byte-level bus master. The block issues a start-with-address command, one write command for each payload byte, and a stop command. Each command is held until the master accepts it. The block then waits for the master's response, which reports whether the target acknowledged.

Playback finishes with a one-cycle `done` pulse. It can also end early with an error flag:
- a target that does not acknowledge,
- a message whose declared length runs past the end of the sequence.

The error flags also give the index of the message that failed.

Top module: `i2c_seq_player`

## Requirements
- R1: When idle, a `sleep_req` pulse plays the sequence at `sleep_base` with `sleep_cnt` bytes, and a `wake_req` pulse plays the one at `wake_base` with `wake_cnt` bytes. If both arrive in the same cycle, the sleep sequence is chosen.
- R2: A message is laid out as a length byte N, then an address byte, then exactly N payload bytes. N counts only the payload bytes.
- R3: A message is sent as follows, and the next message's start is issued only after the stop response has returned:
  - a start command (`cmd_op`=0) with `cmd_data` = address[6:0] shifted left by one, with bit 0 = 0 (write);
  - one write command (`cmd_op`=1) per payload byte, in stored order;
  - a stop command (`cmd_op`=2).
- R4: Messages are issued in stored order. A message identical to an earlier one is still sent in full.
- R5: When the byte count is used up at a message boundary, `busy` falls and `done` is high for exactly one cycle, with no error flag set.
- R6: A length byte of zero ends playback with `done`, and no further commands are issued.
- R7: A negative acknowledge on any byte stops the transaction as follows:
  - the next command is a stop and no further commands follow;
  - `err_nack` rises, and `err_idx` holds the zero-based index of the failing message;
  - no `done` pulse is given.
- R8: A request that arrives while `busy` is high is ignored. The current sequence runs to its end unchanged.
- R9: If a length byte declares more bytes (address plus payload) than remain in the count, `err_fmt` rises and `err_idx` holds that message's index. No command for that message is issued.
- R10: Each byte consumed causes exactly one single-cycle `mem_rd_en` pulse. The block waits for `mem_rd_valid` before using the byte. A command is held stable until `cmd_ready` is seen.
- R11: A sequence with a byte count of zero ends with `done` and issues no read and no command.
- R12: The error flags and `err_idx` stay set until the next accepted request clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request playback of the sleep sequence |
| wake_req | input | 1 | Request playback of the wake sequence |
| sleep_base | input | AW | Store offset of the sleep sequence |
| sleep_cnt | input | CW | Byte count of the sleep sequence |
| wake_base | input | AW | Store offset of the wake sequence |
| wake_cnt | input | CW | Byte count of the wake sequence |
| mem_rd_en | output | 1 | Store read strobe |
| mem_rd_addr | output | AW | Store read address |
| mem_rd_data | input | 8 | Store read data |
| mem_rd_valid | input | 1 | Read data valid, one cycle after the strobe |
| cmd_valid | output | 1 | Bus command valid |
| cmd_op | output | 2 | 0 start+address, 1 write byte, 2 stop |
| cmd_data | output | 8 | Address byte or payload byte |
| cmd_ready | input | 1 | Master accepts the command |
| rsp_valid | input | 1 | Master finished the command |
| rsp_nack | input | 1 | Target did not acknowledge (with `rsp_valid`) |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err_nack | output | 1 | Playback aborted on a missing acknowledge |
| err_fmt | output | 1 | Playback aborted on an overlong message |
| err_idx | output | IW | Index of the message that caused the error |

## Verification
Two functions can meet in one cycle: accepting a new request, and choosing between the two request lines. The bench raises both lines in the same cycle and judges the outcome from the first start command's address, which must belong to the sleep sequence. It also pulses the wake line while the sleep sequence is still playing. The full command log must then match the sleep sequence alone, with a single `done` pulse.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_ADDR,
    S_START,
    S_DATA,
    S_WRITE,
    S_STOP
  } play_st_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_REQ,
    C_WAIT
  } cmd_st_e;

endpackage

// File: rtl/seqp_fetch.sv
module seqp_fetch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          pend,
  output logic          got,
  output logic [7:0]    rbyte,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  input  logic          mem_rd_valid
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (go)
      pend_d = 1'b1;
    else if (mem_rd_valid)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else
      pend_q <= pend_d;
  end

  assign mem_rd_en   = go;
  assign mem_rd_addr = addr;
  assign pend        = pend_q;
  assign got         = pend_q & mem_rd_valid;
  assign rbyte       = mem_rd_data;

endmodule

// File: rtl/seqp_cmd.sv
module seqp_cmd
  import seqp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_op_e    op,
  input  logic [7:0] data,
  output logic       idle,
  output logic       fin,
  output logic       nack,
  output logic       cmd_valid,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_data,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic       rsp_nack
);

  cmd_st_e    st_q, st_d;
  bus_op_e    op_q;
  logic [7:0] data_q;
  logic       ld_en;

  always_comb begin
    st_d  = st_q;
    ld_en = 1'b0;
    case (st_q)
      C_IDLE: if (go) begin
        st_d  = C_REQ;
        ld_en = 1'b1;
      end
      C_REQ:  if (cmd_ready) st_d = C_WAIT;
      C_WAIT: if (rsp_valid) st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= C_IDLE;
    else
      st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_START;
      data_q <= 8'h00;
    end else if (ld_en) begin
      op_q   <= op;
      data_q <= data;
    end
  end

  assign idle      = (st_q == C_IDLE);
  assign fin       = (st_q == C_WAIT) && rsp_valid;
  assign nack      = rsp_nack;
  assign cmd_valid = (st_q == C_REQ);
  assign cmd_op    = op_q;
  assign cmd_data  = data_q;

endmodule

// File: rtl/seqp_ctrl.sv
module seqp_ctrl
  import seqp_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [AW-1:0] sleep_base,
  input  logic [CW-1:0] sleep_cnt,
  input  logic [AW-1:0] wake_base,
  input  logic [CW-1:0] wake_cnt,
  output logic          fetch_go,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_pend,
  input  logic          fetch_got,
  input  logic [7:0]    fetch_byte,
  output logic          cmd_go,
  output bus_op_e       cmd_op_n,
  output logic [7:0]    cmd_data_n,
  input  logic          cmd_idle,
  input  logic          cmd_fin,
  input  logic          cmd_nack,
  output logic          busy,
  output logic          done,
  output logic          err_nack,
  output logic          err_fmt,
  output logic [IW-1:0] err_idx
);

  localparam int LW = ((CW > 8) ? CW : 8) + 1;

  play_st_e      st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [7:0]    plen_q, plen_d;
  logic [6:0]    tgt_q, tgt_d;
  logic [7:0]    dbyte_q, dbyte_d;
  logic [IW-1:0] msg_q, msg_d;
  logic          npend_q, npend_d;
  logic          done_q, done_d;
  logic          enack_q, enack_d;
  logic          efmt_q, efmt_d;
  logic [IW-1:0] eidx_q, eidx_d;
  logic [LW-1:0] need_w, avail_w;
  logic          want_byte;

  assign need_w    = LW'(fetch_byte) + LW'(1);
  assign avail_w   = LW'(rem_q) - LW'(1);
  assign want_byte = !fetch_pend && !fetch_got;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    rem_d      = rem_q;
    plen_d     = plen_q;
    tgt_d      = tgt_q;
    dbyte_d    = dbyte_q;
    msg_d      = msg_q;
    npend_d    = npend_q;
    done_d     = 1'b0;
    enack_d    = enack_q;
    efmt_d     = efmt_q;
    eidx_d     = eidx_q;
    fetch_go   = 1'b0;
    cmd_go     = 1'b0;
    cmd_op_n   = OP_START;
    cmd_data_n = 8'h00;
    case (st_q)
      S_IDLE: begin
        if (sleep_req || wake_req) begin
          ptr_d   = sleep_req ? sleep_base : wake_base;
          rem_d   = sleep_req ? sleep_cnt  : wake_cnt;
          msg_d   = '0;
          npend_d = 1'b0;
          enack_d = 1'b0;
          efmt_d  = 1'b0;
          eidx_d  = '0;
          st_d    = S_LEN;
        end
      end
      S_LEN: begin
        if (rem_q == '0) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          fetch_go = want_byte;
          if (fetch_got) begin
            ptr_d  = ptr_q + AW'(1);
            rem_d  = rem_q - CW'(1);
            plen_d = fetch_byte;
            if (fetch_byte == 8'h00) begin
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else if (need_w > avail_w) begin
              efmt_d = 1'b1;
              eidx_d = msg_q;
              st_d   = S_IDLE;
            end else begin
              st_d = S_ADDR;
            end
          end
        end
      end
      S_ADDR: begin
        fetch_go = want_byte;
        if (fetch_got) begin
          ptr_d = ptr_q + AW'(1);
          rem_d = rem_q - CW'(1);
          tgt_d = fetch_byte[6:0];
          st_d  = S_START;
        end
      end
      S_START: begin
        cmd_op_n   = OP_START;
        cmd_data_n = {tgt_q, 1'b0};
        cmd_go     = cmd_idle;
        if (cmd_fin) begin
          if (cmd_nack) begin
            npend_d = 1'b1;
            st_d    = S_STOP;
          end else begin
            st_d = S_DATA;
          end
        end
      end
      S_DATA: begin
        fetch_go = want_byte;
        if (fetch_got) begin
          ptr_d   = ptr_q + AW'(1);
          rem_d   = rem_q - CW'(1);
          dbyte_d = fetch_byte;
          plen_d  = plen_q - 8'd1;
          st_d    = S_WRITE;
        end
      end
      S_WRITE: begin
        cmd_op_n   = OP_WRITE;
        cmd_data_n = dbyte_q;
        cmd_go     = cmd_idle;
        if (cmd_fin) begin
          if (cmd_nack) begin
            npend_d = 1'b1;
            st_d    = S_STOP;
          end else if (plen_q == 8'h00) begin
            st_d = S_STOP;
          end else begin
            st_d = S_DATA;
          end
        end
      end
      S_STOP: begin
        cmd_op_n = OP_STOP;
        cmd_go   = cmd_idle;
        if (cmd_fin) begin
          if (npend_q) begin
            enack_d = 1'b1;
            eidx_d  = msg_q;
            st_d    = S_IDLE;
          end else begin
            msg_d = msg_q + IW'(1);
            st_d  = S_LEN;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      enack_q <= 1'b0;
      efmt_q  <= 1'b0;
      npend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      enack_q <= enack_d;
      efmt_q  <= efmt_d;
      npend_q <= npend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      plen_q  <= 8'h00;
      tgt_q   <= 7'h00;
      dbyte_q <= 8'h00;
      msg_q   <= '0;
      eidx_q  <= '0;
    end else begin
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      plen_q  <= plen_d;
      tgt_q   <= tgt_d;
      dbyte_q <= dbyte_d;
      msg_q   <= msg_d;
      eidx_q  <= eidx_d;
    end
  end

  assign fetch_addr = ptr_q;
  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign err_nack   = enack_q;
  assign err_fmt    = efmt_q;
  assign err_idx    = eidx_q;

endmodule

// File: rtl/i2c_seq_player.sv
module i2c_seq_player
  import seqp_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [AW-1:0] sleep_base,
  input  logic [CW-1:0] sleep_cnt,
  input  logic [AW-1:0] wake_base,
  input  logic [CW-1:0] wake_cnt,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  input  logic          mem_rd_valid,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  input  logic          cmd_ready,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  output logic          busy,
  output logic          done,
  output logic          err_nack,
  output logic          err_fmt,
  output logic [IW-1:0] err_idx
);

  logic          f_go, f_pend, f_got;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_byte;
  logic          c_go, c_idle, c_fin, c_nack;
  bus_op_e       c_op;
  logic [7:0]    c_data;

  seqp_ctrl #(.AW(AW), .CW(CW), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .sleep_base (sleep_base),
    .sleep_cnt  (sleep_cnt),
    .wake_base  (wake_base),
    .wake_cnt   (wake_cnt),
    .fetch_go   (f_go),
    .fetch_addr (f_addr),
    .fetch_pend (f_pend),
    .fetch_got  (f_got),
    .fetch_byte (f_byte),
    .cmd_go     (c_go),
    .cmd_op_n   (c_op),
    .cmd_data_n (c_data),
    .cmd_idle   (c_idle),
    .cmd_fin    (c_fin),
    .cmd_nack   (c_nack),
    .busy       (busy),
    .done       (done),
    .err_nack   (err_nack),
    .err_fmt    (err_fmt),
    .err_idx    (err_idx)
  );

  seqp_fetch #(.AW(AW)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (f_go),
    .addr         (f_addr),
    .pend         (f_pend),
    .got          (f_got),
    .rbyte        (f_byte),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_valid (mem_rd_valid)
  );

  seqp_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (c_go),
    .op        (c_op),
    .data      (c_data),
    .idle      (c_idle),
    .fin       (c_fin),
    .nack      (c_nack),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack)
  );

endmodule

// File: rtl/seqp_checker.sv
module seqp_checker #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_data,
  input logic          cmd_ready,
  input logic          busy,
  input logic          done,
  input logic          err_nack,
  input logic          err_fmt,
  input logic [IW-1:0] err_idx
);

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R10

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data)); // R10

  AST_START_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 2'd0) |-> !cmd_data[0]); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !mem_rd_en); // R5

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err_nack && !err_fmt); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_nack && err_fmt)); // R7

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_nack && !busy && $past(!busy) |-> $stable(err_idx)); // R12

endmodule

bind i2c_seq_player seqp_checker #(.IW(IW)) u_seqp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd_en (mem_rd_en),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .err_nack  (err_nack),
  .err_fmt   (err_fmt),
  .err_idx   (err_idx)
);

// File: tb/i2c_seq_player_bench.sv
`timescale 1ns/1ps
module i2c_seq_player_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0, wake_req = 1'b0;
  logic [7:0] sleep_base = 8'd0, sleep_cnt = 8'd0, wake_base = 8'd0, wake_cnt = 8'd0;
  logic       mem_rd_en;
  logic [7:0] mem_rd_addr;
  logic [7:0] mem_rd_data = 8'h00;
  logic       mem_rd_valid = 1'b0;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic       busy, done, err_nack, err_fmt;
  logic [7:0] err_idx;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mem [0:255];
  int  ncmd = 0, nrd = 0, ndone = 0, nack_at = -1;
  int  log_op [0:31];
  int  log_dat [0:31];
  logic log_clr = 1'b0;
  logic nack_this = 1'b0;
  int  rdly = 0;

  always #2.5 clk = ~clk;

  i2c_seq_player u_i2c_seq_player (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .sleep_base(sleep_base), .sleep_cnt(sleep_cnt), .wake_base(wake_base), .wake_cnt(wake_cnt),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_valid(mem_rd_valid), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .busy(busy),
    .done(done), .err_nack(err_nack), .err_fmt(err_fmt), .err_idx(err_idx)
  );

  // store model, one cycle read latency
  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  // bus master model and logger
  always @(posedge clk) begin
    if (log_clr) begin
      ncmd <= 0; nrd <= 0; ndone <= 0;
    end else begin
      if (mem_rd_en) nrd <= nrd + 1;
      if (done) ndone <= ndone + 1;
      if (cmd_valid && cmd_ready) begin
        if (ncmd < 32) begin
          log_op[ncmd]  <= int'(cmd_op);
          log_dat[ncmd] <= int'(cmd_data);
        end
        nack_this <= (ncmd == nack_at);
        ncmd <= ncmd + 1;
      end
    end
    cmd_ready <= cmd_valid && !cmd_ready;
    if (cmd_valid && cmd_ready) rdly <= 2;
    else if (rdly != 0) rdly <= rdly - 1;
    rsp_valid <= (rdly == 1);
    rsp_nack  <= (rdly == 1) && nack_this;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_cmd(input string req, input int i, input int op, input int dat);
    check(req, log_op[i], op);
    if (op != 2) check(req, log_dat[i], dat);
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic w);
    @(negedge clk); sleep_req = s; wake_req = w;
    @(negedge clk); sleep_req = 1'b0; wake_req = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (done || err_nack || err_fmt) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5 reset busy", busy, 0);
    check("R5 reset done", done, 0);
    check("R12 reset errs", {err_nack, err_fmt}, 0);
    check("R10 reset cmd_valid", cmd_valid, 0);
    check("R10 reset rd_en", mem_rd_en, 0);
  endtask

  task automatic t_sleep_full();
    clear_log(); nack_at = -1;
    pulse(1'b1, 1'b0);
    wait_end();
    check("R5 sleep done pulses", ndone, 1);
    check("R5 sleep no err", {err_nack, err_fmt}, 0);
    check("R4 sleep cmd count", ncmd, 11);
    check("R10 sleep reads", nrd, 11);
    exp_cmd("R3 m0 start", 0, 0, 8'h48);
    exp_cmd("R2 m0 w0", 1, 1, 8'h0b);
    exp_cmd("R2 m0 w1", 2, 1, 8'h6d);
    exp_cmd("R3 m0 stop", 3, 2, 0);
    exp_cmd("R4 m1 start", 4, 0, 8'h48);
    exp_cmd("R4 m1 w0", 5, 1, 8'h0b);
    exp_cmd("R4 m1 w1", 6, 1, 8'h6d);
    exp_cmd("R4 m1 stop", 7, 2, 0);
    exp_cmd("R3 m2 start", 8, 0, 8'h62);
    exp_cmd("R2 m2 w0", 9, 1, 8'h55);
    exp_cmd("R3 m2 stop", 10, 2, 0);
  endtask

  task automatic t_wake_zero_len();
    clear_log(); nack_at = -1;
    pulse(1'b0, 1'b1);
    wait_end();
    check("R6 zero len done", ndone, 1);
    check("R6 zero len cmds", ncmd, 3);
    check("R6 zero len reads", nrd, 4);
    exp_cmd("R1 wake start", 0, 0, 8'ha0);
    exp_cmd("R1 wake w0", 1, 1, 8'haa);
    exp_cmd("R6 wake stop", 2, 2, 0);
  endtask

  task automatic t_both_and_busy();
    clear_log(); nack_at = -1;
    pulse(1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check("R8 busy mid", busy, 1);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    wait_end();
    check("R1 both pick sleep", log_dat[0], 8'h48);
    check("R8 ignored cmds", ncmd, 11);
    check("R8 ignored done", ndone, 1);
    exp_cmd("R8 last start sleep", 8, 0, 8'h62);
  endtask

  task automatic t_nack();
    clear_log(); nack_at = 5;
    pulse(1'b1, 1'b0);
    wait_end();
    check("R7 err_nack", err_nack, 1);
    check("R7 err_idx", int'(err_idx), 1);
    check("R7 cmds", ncmd, 7);
    exp_cmd("R7 stop after nack", 6, 2, 0);
    check("R7 no done", ndone, 0);
    repeat (10) @(negedge clk);
    check("R12 err held", err_nack, 1);
    check("R7 quiet after", ncmd, 7);
    nack_at = -1;
  endtask

  task automatic t_fmt();
    clear_log(); nack_at = -1;
    wake_base = 8'd64; wake_cnt = 8'd6;
    pulse(1'b0, 1'b1);
    check("R12 flags cleared", err_nack, 0);
    wait_end();
    check("R9 err_fmt", err_fmt, 1);
    check("R9 err_idx", int'(err_idx), 1);
    check("R9 cmds", ncmd, 3);
    check("R9 reads", nrd, 4);
    check("R9 no done", ndone, 0);
  endtask

  task automatic t_zero_cnt();
    clear_log(); nack_at = -1;
    sleep_cnt = 8'd0;
    pulse(1'b1, 1'b0);
    wait_end();
    check("R11 done", ndone, 1);
    check("R11 no cmds", ncmd, 0);
    check("R11 no reads", nrd, 0);
    check("R12 fmt cleared", err_fmt, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // sleep at 0
    mem[0] = 8'd2; mem[1] = 8'h24; mem[2] = 8'h0b; mem[3] = 8'h6d;
    mem[4] = 8'd2; mem[5] = 8'h24; mem[6] = 8'h0b; mem[7] = 8'h6d;
    mem[8] = 8'd1; mem[9] = 8'h31; mem[10] = 8'h55;
    // wake at 32 with early zero length
    mem[32] = 8'd1; mem[33] = 8'h50; mem[34] = 8'haa; mem[35] = 8'd0;
    mem[36] = 8'd1; mem[37] = 8'h51; mem[38] = 8'h11;
    // overlong message at 64
    mem[64] = 8'd1; mem[65] = 8'h20; mem[66] = 8'h01;
    mem[67] = 8'd3; mem[68] = 8'h21; mem[69] = 8'h02;
    sleep_base = 8'd0;  sleep_cnt = 8'd11;
    wake_base  = 8'd32; wake_cnt  = 8'd7;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_sleep_full();
    t_wake_zero_len();
    t_both_and_busy();
    t_nack();
    t_fmt();
    t_zero_cnt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule